// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This block keeps wall-clock time as a 32-bit count of seconds. A prescaler counts reference clock cycles up to a programmable frequency word and emits one tick per second, and each tick advances the seconds count. Software reaches the block through a small synchronous register port with 16-bit data. It sets a new time by writing a 32-bit preset and raising a load bit. It reads the time by raising a snapshot bit and then reading a stable 32-bit copy. Both bits drop by themselves once the hardware has acted on them.

A 32-bit match value is compared with the count. When the count becomes equal to it, a sticky alarm flag is set. The flag, together with a software force bit, drives a level-high interrupt that software can mask. A write-one clear bit drops the flag. A soft reset bit, active low, puts the time base and the alarm back to zero but leaves the configuration untouched.

Register byte offsets: 0x00 control, 0x04/0x08 frequency word low/high, 0x0C/0x10 preset low/high, 0x14/0x18 match low/high, 0x1C status, 0x20/0x24 snapshot low/high. Control bits: 0 run (soft reset when 0), 1 count enable, 2 rollover enable, 3 load, 4 snapshot, 5 interrupt mask, 6 interrupt force, 7 alarm clear. Status bits: 0 raw interrupt, 1 alarm flag.

Top module: `secs_alarm_top`

## Requirements
- R1: After reset the control register reads 0x0021 (run bit 1, mask bit 5 set, all else 0). The frequency word, status and snapshot read 0, and `irq` is low.
- R2: The frequency, preset and match halves read back what was written at their offsets. An unmapped offset such as 0x28 reads 0.
- R3: Writing control bit 3 copies the 32-bit preset into the count on the next clock edge. Bit 3 reads 1 for that one cycle and then reads 0.
- R4: Writing control bit 4 copies the count into the snapshot at 0x20 (low) and 0x24 (high) on the next clock edge. Bit 4 reads 1 for that one cycle and then reads 0.
- R5: With a frequency word N of 2 or more, the count advances once per N enabled clocks. With N of 0 or 1 it advances on every enabled clock.
- R6: With control bit 1 at 0 the count and prescaler hold their values. Bit 1 reads back as written.
- R7: On a tick at 0xFFFFFFFF, the count goes to 0 when control bit 2 is 1 and stays at 0xFFFFFFFF when bit 2 is 0.
- R8: When the count becomes equal to the match value, whether by ticking or by a load, status bit 1 sets one cycle later and stays set. Status bit 0 is bit 1 OR the force bit.
- R9: `irq` equals status bit 0 while control bit 5 is 0, and is low while bit 5 is 1.
- R10: While control bit 6 is 1, status bit 0 is 1 and status bit 1 is unaffected.
- R11: Writing control bit 7 clears status bit 1 one cycle later. Bit 7 reads 1 for one cycle and then reads 0.
- R12: With control bit 0 at 0, the count, prescaler and alarm flag clear. The frequency, preset and match registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_rdata | output | 16 | Read data, 0 when no read is strobed |
| irq | output | 1 | Level-high alarm interrupt |

## Verification
The bench runs the prescaler at word 5, counts the exact enabled cycles, and expects a precise count. A prescaler that is off by one drifts by a whole tick and fails that check. It steps the count across 0xFFFFFFFF in both rollover modes; a design that ignores the mode either wraps when it should hold or sticks at the top when it should wrap. It raises the alarm once by ticking and once by a load, then masks, clears and forces it. A flag that is not sticky, or a clear that is ignored, shows up in the status word and in `irq`. A soft reset must zero the time while the configuration reads back intact; a design that wipes the configuration fails those reads.

// File: rtl/secs_pkg.sv
package secs_pkg;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 2 * DATA_W;

  localparam int OFF_CTRL     = 'h00;
  localparam int OFF_FREQ_LO  = 'h04;
  localparam int OFF_FREQ_HI  = 'h08;
  localparam int OFF_PRE_LO   = 'h0C;
  localparam int OFF_PRE_HI   = 'h10;
  localparam int OFF_MATCH_LO = 'h14;
  localparam int OFF_MATCH_HI = 'h18;
  localparam int OFF_STATUS   = 'h1C;
  localparam int OFF_SNAP_LO  = 'h20;
  localparam int OFF_SNAP_HI  = 'h24;

  typedef logic [CNT_W-1:0] cnt_t;

  // bit 7 down to bit 0 of the control word
  typedef struct packed {
    logic clr;
    logic force_on;
    logic mask;
    logic snap;
    logic load;
    logic wrap;
    logic en;
    logic run;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = 8'h21;

  // next value of the seconds count on a tick
  function automatic cnt_t count_step(input cnt_t c, input logic wrap);
    if (c == '1) return wrap ? '0 : c;
    return c + 1'b1;
  endfunction

  // prescaler has reached the end of one second
  function automatic logic tick_due(input cnt_t pre, input cnt_t freq);
    if (freq <= cnt_t'(1)) return 1'b1;
    return pre >= (freq - 1'b1);
  endfunction
endpackage

// File: rtl/secs_regs.sv
module secs_regs
  import secs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  input  logic              alarm_flag,
  input  logic              raw_irq,
  input  cnt_t              snap_val,
  output ctrl_t             ctrl,
  output cnt_t              freq,
  output cnt_t              preset,
  output cnt_t              match
);
  ctrl_t ctrl_q;
  cnt_t  freq_q, pre_q, match_q;
  logic  ctrl_wr;

  assign ctrl_wr = wr && (addr == ADDR_W'(OFF_CTRL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      freq_q  <= '0;
      pre_q   <= '0;
      match_q <= '0;
    end else begin
      ctrl_q.load <= 1'b0;
      ctrl_q.snap <= 1'b0;
      ctrl_q.clr  <= 1'b0;
      if (wr) begin
        case (addr)
          ADDR_W'(OFF_CTRL):     ctrl_q <= ctrl_t'(wdata[7:0]);
          ADDR_W'(OFF_FREQ_LO):  freq_q[DATA_W-1:0] <= wdata;
          ADDR_W'(OFF_FREQ_HI):  freq_q[CNT_W-1:DATA_W] <= wdata;
          ADDR_W'(OFF_PRE_LO):   pre_q[DATA_W-1:0] <= wdata;
          ADDR_W'(OFF_PRE_HI):   pre_q[CNT_W-1:DATA_W] <= wdata;
          ADDR_W'(OFF_MATCH_LO): match_q[DATA_W-1:0] <= wdata;
          ADDR_W'(OFF_MATCH_HI): match_q[CNT_W-1:DATA_W] <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (addr)
        ADDR_W'(OFF_CTRL):     rdata = {{(DATA_W-8){1'b0}}, ctrl_q};
        ADDR_W'(OFF_FREQ_LO):  rdata = freq_q[DATA_W-1:0];
        ADDR_W'(OFF_FREQ_HI):  rdata = freq_q[CNT_W-1:DATA_W];
        ADDR_W'(OFF_PRE_LO):   rdata = pre_q[DATA_W-1:0];
        ADDR_W'(OFF_PRE_HI):   rdata = pre_q[CNT_W-1:DATA_W];
        ADDR_W'(OFF_MATCH_LO): rdata = match_q[DATA_W-1:0];
        ADDR_W'(OFF_MATCH_HI): rdata = match_q[CNT_W-1:DATA_W];
        ADDR_W'(OFF_STATUS):   rdata = {{(DATA_W-2){1'b0}}, alarm_flag, raw_irq};
        ADDR_W'(OFF_SNAP_LO):  rdata = snap_val[DATA_W-1:0];
        ADDR_W'(OFF_SNAP_HI):  rdata = snap_val[CNT_W-1:DATA_W];
        default:               rdata = '0;
      endcase
    end
  end

  assign ctrl   = ctrl_q;
  assign freq   = freq_q;
  assign preset = pre_q;
  assign match  = match_q;

  AST_LOAD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.load && !ctrl_wr |=> !ctrl_q.load); // R3
  AST_SNAP_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.snap && !ctrl_wr |=> !ctrl_q.snap); // R4
  AST_CLR_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.clr && !ctrl_wr |=> !ctrl_q.clr); // R11
endmodule

// File: rtl/secs_tick_gen.sv
module secs_tick_gen
  import secs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic en,
  input  cnt_t freq,
  output logic tick
);
  cnt_t pre_q;

  assign tick = run && en && tick_due(pre_q, freq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (!run)   pre_q <= '0;
    else if (en)     pre_q <= tick ? '0 : pre_q + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (freq > cnt_t'(1)) |=> !tick || (freq <= cnt_t'(1))); // R5
  AST_PRESCALE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    run && !en |=> $stable(pre_q)); // R6
endmodule

// File: rtl/secs_counter.sv
module secs_counter
  import secs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic load,
  input  cnt_t preset,
  input  logic tick,
  input  logic wrap,
  input  logic snap_req,
  output cnt_t count,
  output cnt_t snap_val
);
  cnt_t cnt_q, snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (load)   cnt_q <= preset;
    else if (tick)   cnt_q <= count_step(cnt_q, wrap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        snap_q <= '0;
    else if (snap_req) snap_q <= cnt_q;
  end

  assign count    = cnt_q;
  assign snap_val = snap_q;

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    run && load |=> cnt_q == $past(preset)); // R3
  AST_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |=> snap_q == $past(cnt_q)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    run && !load && !tick |=> $stable(cnt_q)); // R6
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    run && !load && !wrap && (cnt_q == '1) |=> cnt_q == '1); // R7
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0); // R12
endmodule

// File: rtl/secs_alarm.sv
module secs_alarm
  import secs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  cnt_t count,
  input  cnt_t match,
  input  logic mask,
  input  logic force_on,
  input  logic clr,
  output logic flag,
  output logic raw,
  output logic irq
);
  logic eq, eq_prev_q, hit, flag_q;

  assign eq  = (count == match);
  assign hit = run && eq && !eq_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_prev_q <= 1'b1;
    else        eq_prev_q <= run ? eq : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (!run)  flag_q <= 1'b0;
    else if (hit)   flag_q <= 1'b1;
    else if (clr)   flag_q <= 1'b0;
  end

  assign flag = flag_q;
  assign raw  = flag_q | force_on;
  assign irq  = raw & ~mask;

  AST_ALARM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q); // R8
  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    run && flag_q && !clr |=> flag_q); // R8
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !hit |=> !flag_q); // R11
  AST_SOFT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !flag_q); // R12
endmodule

// File: rtl/secs_alarm_top.sv
module secs_alarm_top
  import secs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [15:0]       bus_rdata,
  output logic              irq
);
  ctrl_t ctrl;
  cnt_t  freq, preset, match, count, snap_val;
  logic  tick, alarm_flag, raw_irq;

  secs_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .rd(bus_rd), .rdata(bus_rdata), .alarm_flag(alarm_flag), .raw_irq(raw_irq),
    .snap_val(snap_val), .ctrl(ctrl), .freq(freq), .preset(preset), .match(match)
  );

  secs_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .en(ctrl.en), .freq(freq), .tick(tick)
  );

  secs_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .load(ctrl.load), .preset(preset),
    .tick(tick), .wrap(ctrl.wrap), .snap_req(ctrl.snap), .count(count), .snap_val(snap_val)
  );

  secs_alarm u_alarm (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .count(count), .match(match),
    .mask(ctrl.mask), .force_on(ctrl.force_on), .clr(ctrl.clr),
    .flag(alarm_flag), .raw(raw_irq), .irq(irq)
  );

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.mask |-> !irq); // R9
  AST_FORCE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.force_on && !ctrl.mask |-> irq); // R10
endmodule

// File: tb/secs_alarm_top_bench.sv
module secs_alarm_top_bench;
  localparam logic [5:0] A_CTRL = 6'h00, A_FREQ = 6'h04, A_PRE = 6'h0C,
                         A_MATCH = 6'h14, A_STAT = 6'h1C, A_SNAP = 6'h20, A_NONE = 6'h28;

  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, rd = 1'b0, irq;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  secs_alarm_top u_secs_alarm_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rd(rd), .bus_rdata(rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [15:0] d);
    addr = a; rd = 1'b1; #1; d = rdata; rd = 1'b0;
  endtask

  task automatic write32(input logic [5:0] a, input logic [31:0] v);
    bus_write(a, v[15:0]); bus_write(a + 6'd4, v[31:16]);
  endtask

  task automatic read32(input logic [5:0] a, output logic [31:0] v);
    logic [15:0] lo, hi;
    bus_read(a, lo); bus_read(a + 6'd4, hi); v = {hi, lo};
  endtask

  task automatic take_snapshot(input logic [15:0] base, output logic [31:0] v);
    logic [15:0] c;
    bus_write(A_CTRL, base | 16'h0010);
    bus_read(A_CTRL, c); check("R4 snapshot bit pending", c[4], 1'b1);
    @(negedge clk);
    bus_read(A_CTRL, c); check("R4 snapshot bit self-clears", c[4], 1'b0);
    read32(A_SNAP, v);
  endtask

  task automatic restart;
    bus_write(A_CTRL, 16'h0020); bus_write(A_CTRL, 16'h0021);
  endtask

  task automatic t_reset;
    logic [15:0] d; logic [31:0] v;
    bus_read(A_CTRL, d);  check("R1 control reset", d, 16'h0021);
    read32(A_FREQ, v);    check("R1 freq reset", v, 0);
    bus_read(A_STAT, d);  check("R1 status reset", d, 0);
    read32(A_SNAP, v);    check("R1 snapshot reset", v, 0);
    check("R1 irq reset", irq, 1'b0);
  endtask

  task automatic t_regs;
    logic [31:0] v; logic [15:0] d;
    write32(A_FREQ, 32'h00B7_1B00);  read32(A_FREQ, v);  check("R2 freq readback", v, 32'h00B7_1B00);
    write32(A_PRE, 32'h1234_5678);   read32(A_PRE, v);   check("R2 preset readback", v, 32'h1234_5678);
    write32(A_MATCH, 32'hA5A5_0F0F); read32(A_MATCH, v); check("R2 match readback", v, 32'hA5A5_0F0F);
    bus_read(A_NONE, d); check("R2 unmapped reads zero", d, 0);
  endtask

  task automatic t_load;
    logic [15:0] c; logic [31:0] v;
    restart();
    write32(A_PRE, 32'hCAFE_0001);
    bus_write(A_CTRL, 16'h0029);
    bus_read(A_CTRL, c); check("R3 load bit pending", c[3], 1'b1);
    @(negedge clk);
    bus_read(A_CTRL, c); check("R3 load bit self-clears", c[3], 1'b0);
    take_snapshot(16'h0021, v); check("R3 loaded count", v, 32'hCAFE_0001);
  endtask

  task automatic t_prescale(input logic [31:0] fw, input int wait_n, input logic [31:0] exp);
    logic [31:0] v; logic [15:0] c;
    restart();
    write32(A_FREQ, fw); write32(A_PRE, 32'd100);
    bus_write(A_CTRL, 16'h0029);
    bus_write(A_CTRL, 16'h0023);
    bus_read(A_CTRL, c); check("R6 enable reads back", c, 16'h0023);
    repeat (wait_n) @(negedge clk);
    bus_write(A_CTRL, 16'h0021);
    take_snapshot(16'h0021, v); check($sformatf("R5 count with freq word %0d", fw), v, exp);
    repeat (15) @(negedge clk);
    take_snapshot(16'h0021, v); check("R6 count holds while disabled", v, exp);
    bus_read(A_CTRL, c); check("R6 enable bit reads zero", c[1], 1'b0);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    restart(); write32(A_FREQ, 32'd1); write32(A_PRE, 32'hFFFF_FFFE);
    bus_write(A_CTRL, 16'h002D); bus_write(A_CTRL, 16'h0027); bus_write(A_CTRL, 16'h0025);
    take_snapshot(16'h0025, v); check("R7 rollover to zero", v, 32'h0);
    restart();
    bus_write(A_CTRL, 16'h0029); bus_write(A_CTRL, 16'h0023); bus_write(A_CTRL, 16'h0021);
    take_snapshot(16'h0021, v); check("R7 holds at top", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_alarm;
    logic [15:0] d;
    restart(); write32(A_FREQ, 32'd1); write32(A_MATCH, 32'd200); write32(A_PRE, 32'd198);
    bus_write(A_CTRL, 16'h0009);
    bus_read(A_STAT, d); check("R8 no alarm before match", d, 16'h0);
    bus_write(A_CTRL, 16'h0003);
    repeat (4) @(negedge clk);
    bus_write(A_CTRL, 16'h0001);
    bus_read(A_STAT, d); check("R8 alarm flag and raw set", d, 16'h3);
    check("R9 irq unmasked", irq, 1'b1);
    bus_write(A_CTRL, 16'h0021);
    check("R9 irq masked", irq, 1'b0);
    bus_read(A_STAT, d); check("R8 flag stays while masked", d, 16'h3);
  endtask

  task automatic t_clear;
    logic [15:0] d;
    bus_write(A_CTRL, 16'h00A1);
    bus_read(A_CTRL, d); check("R11 clear bit pending", d[7], 1'b1);
    @(negedge clk);
    bus_read(A_CTRL, d); check("R11 clear bit self-clears", d[7], 1'b0);
    bus_read(A_STAT, d); check("R11 flag cleared", d, 16'h0);
  endtask

  task automatic t_force;
    logic [15:0] d;
    bus_write(A_CTRL, 16'h0041);
    bus_read(A_STAT, d); check("R10 force sets raw only", d, 16'h1);
    check("R10 irq forced", irq, 1'b1);
    bus_write(A_CTRL, 16'h0061);
    check("R9 forced irq masked", irq, 1'b0);
    bus_write(A_CTRL, 16'h0021);
    bus_read(A_STAT, d); check("R10 force released", d, 16'h0);
  endtask

  task automatic t_soft_reset;
    logic [15:0] d; logic [31:0] v;
    write32(A_PRE, 32'd200);
    bus_write(A_CTRL, 16'h0029);
    repeat (2) @(negedge clk);
    bus_read(A_STAT, d); check("R8 alarm on load to match", d, 16'h3);
    bus_write(A_CTRL, 16'h0020);
    @(negedge clk);
    bus_read(A_STAT, d); check("R12 soft reset clears flag", d, 16'h0);
    bus_write(A_CTRL, 16'h0021);
    read32(A_FREQ, v);  check("R12 freq kept", v, 32'd1);
    read32(A_MATCH, v); check("R12 match kept", v, 32'd200);
    read32(A_PRE, v);   check("R12 preset kept", v, 32'd200);
    take_snapshot(16'h0021, v); check("R12 count cleared", v, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_regs();
    t_load();
    t_prescale(32'd5, 20, 32'd104);
    t_prescale(32'd1, 10, 32'd112);
    t_prescale(32'd0, 10, 32'd112);
    t_wrap();
    t_alarm();
    t_clear();
    t_force();
    t_soft_reset();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule